// File: doc/BRIEF.md
# Serial Bit-Rate Generator with Majority-Voted Receive Sampling

This block produces the timing for a serial port that runs either asynchronously or synchronously. An 8-bit divisor `n` controls a free-running down-counter that fires a base tick once every `n+1` system clocks. Four base ticks form one oversample tick. A mode-selected count of oversample ticks forms one bit period: 16 in low-speed asynchronous mode, 4 in high-speed asynchronous mode and 1 in synchronous mode. The resulting bit rate is the clock divided by 64, 16 or 4 times `n+1`. In synchronous mode the block also drives a clock that completes one full period per bit.

The block samples the raw receive line three times near the middle of each bit. The level seen on at least two of the three samples becomes the received level. That level is updated once per bit strobe. A divisor write takes effect at once: all counters restart, so the new rate starts without waiting for the old period to expire. Dropping the enable holds all counters at their reload state.

There is no data stream at this block's edge, so it has no valid/ready handshake and no back-pressure. Every pin is a plain control or status signal. The strobes are single-cycle pulses that a downstream shifter must consume in the cycle they appear.

Top module: `brg_bitrate_gen`

## Requirements
- R1: The base counter restarts at `n`. Cycle 0 is the first cycle after a divisor write, or the first cycle with `enable` high. A base tick occurs in cycles k = m*(n+1)-1. `os_tick` is high in exactly those cycles where m is a multiple of 4, so its period is 4*(n+1) clocks.
- R2: With `sync_mode`=0 and `high_speed`=0, `bit_strobe` is high in exactly the cycles k = j*64*(n+1)-1. For n=25 this gives a period of 1664 clocks, which is about 9615 bit/s from 16 MHz.
- R3: With `sync_mode`=0 and `high_speed`=1, `bit_strobe` is high in exactly the cycles k = j*16*(n+1)-1.
- R4: With `sync_mode`=1, `bit_strobe` is high in exactly the cycles k = j*4*(n+1)-1, and `high_speed` has no effect. In cycle k, `sync_clk` equals bit 1 of floor(k/(n+1)), so it rises after 2*(n+1) clocks and falls at each bit boundary. In asynchronous modes `sync_clk` is 0.
- R5: A cycle with `div_write` high produces no tick or strobe. It loads `div_value` and restarts every counter, including a counter in mid-period. The next cycle is cycle 0 of R1.
- R6: The line is sampled at the clock edge ending each sample cycle. In asynchronous modes the sample cycles are the oversample ticks whose index within the bit is L/2-1, L/2 and L/2+1, where L is 16 or 4. In synchronous mode they are the base ticks with index 1, 2 and 3 within the bit. The voted level is the majority of the three samples.
- R7: `rx_level` changes only in the cycle after a `bit_strobe`. It then holds the majority of the three samples of the bit that just ended.
- R8: While `enable` is low, `bit_strobe` and `os_tick` are 0. From the second low cycle onward `sync_clk` is also 0. When `enable` rises without a write, timing restarts as in R1.
- R9: During reset and after it, the block is in a defined state: the strobes and `sync_clk` are 0, `rx_level` is 1 and the divisor is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the generator; low holds all counters at reload |
| sync_mode | input | 1 | 1 = synchronous mode (divide by 4), 0 = asynchronous |
| high_speed | input | 1 | Asynchronous only: 1 = divide by 16, 0 = divide by 64 |
| div_value | input | 8 | New divisor value n |
| div_write | input | 1 | Loads `div_value` and restarts all counters |
| rx_raw | input | 1 | Raw receive line, already synchronous to `clk` |
| bit_strobe | output | 1 | One-cycle pulse at the last cycle of each bit |
| os_tick | output | 1 | One-cycle oversample pulse every 4*(n+1) clocks |
| sync_clk | output | 1 | Synchronous-mode clock, one period per bit |
| rx_level | output | 1 | Majority-voted receive level, updated once per bit |

## Verification
The assertions assume that `rx_raw` is already synchronous to `clk`, and that `sync_mode` and `high_speed` change only together with a divisor write or while the block is disabled. The bench keeps to this: it changes the mode only in the same cycle as `div_write` and drives every input at the falling clock edge. Between sample cycles it drives the receive line to the opposite of the expected vote, so only the three chosen samples can produce the checked level.

// File: rtl/brg_pkg.sv
package brg_pkg;
  // Base ticks per oversample tick, and oversample ticks per bit per mode.
  localparam int SUB_PER_OS = 4;
  localparam int OS_PER_BIT_LO = 16;
  localparam int OS_PER_BIT_HI = 4;
  localparam int OS_PER_BIT_SY = 1;

  typedef enum logic [1:0] {
    MODE_ASYNC_LO = 2'd0,
    MODE_ASYNC_HI = 2'd1,
    MODE_SYNC     = 2'd2
  } brg_mode_e;

  function automatic brg_mode_e decode_mode(input logic sync_sel, input logic hs_sel);
    if (sync_sel) return MODE_SYNC;
    else if (hs_sel) return MODE_ASYNC_HI;
    else return MODE_ASYNC_LO;
  endfunction
endpackage

// File: rtl/brg_divider.sv
module brg_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             div_write,
  input  logic [DIV_W-1:0] div_value,
  output logic             base_tick,
  output logic             restart
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt_q;

  assign restart   = div_write | ~enable;
  assign base_tick = enable & ~div_write & (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else begin
      if (div_write) div_q <= div_value;
      if (div_write)        cnt_q <= div_value;
      else if (!enable)     cnt_q <= div_q;
      else if (cnt_q == '0) cnt_q <= div_q;
      else                  cnt_q <= cnt_q - 1'b1;
    end
  end

  // R1: two base ticks in a row only when the divisor is zero
  p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    base_tick |=> (!base_tick || div_q == '0));

  // R5: after a write the counter starts a full period
  p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    div_write |=> (!base_tick || div_q == '0));
endmodule

// File: rtl/brg_prescaler.sv
module brg_prescaler
  import brg_pkg::*;
#(
  parameter int SUB_N = SUB_PER_OS,
  parameter int OS_LO = OS_PER_BIT_LO,
  parameter int OS_HI = OS_PER_BIT_HI,
  parameter int OS_SY = OS_PER_BIT_SY,
  localparam int SUB_W = $clog2(SUB_N),
  localparam int OS_W  = $clog2(OS_LO),
  localparam int LIM_W = OS_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             base_tick,
  input  logic             sync_mode,
  input  logic             high_speed,
  output logic             os_tick,
  output logic             bit_strobe,
  output logic             sync_clk,
  output logic [SUB_W-1:0] sub_idx,
  output logic [OS_W-1:0]  os_idx,
  output logic [LIM_W-1:0] os_limit
);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUB_N - 1);
  localparam logic [SUB_W-1:0] SUB_HALF = SUB_W'(SUB_N / 2 - 1);

  brg_mode_e mode;
  logic [SUB_W-1:0] sub_q;
  logic [OS_W-1:0]  os_q;
  logic             sclk_q;
  logic             os_wrap;

  assign mode = decode_mode(sync_mode, high_speed);

  always_comb begin
    unique case (mode)
      MODE_SYNC:     os_limit = LIM_W'(OS_SY);
      MODE_ASYNC_HI: os_limit = LIM_W'(OS_HI);
      default:       os_limit = LIM_W'(OS_LO);
    endcase
  end

  assign os_tick    = base_tick & (sub_q == SUB_LAST);
  assign os_wrap    = ({1'b0, os_q} >= (os_limit - 1'b1));
  assign bit_strobe = os_tick & os_wrap;
  assign sync_clk   = sclk_q;
  assign sub_idx    = sub_q;
  assign os_idx     = os_q;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      sub_q  <= '0;
      os_q   <= '0;
      sclk_q <= 1'b0;
    end else begin
      if (base_tick) sub_q <= sub_q + 1'b1;
      if (os_tick) os_q <= os_wrap ? '0 : os_q + 1'b1;
      if (!sync_mode) sclk_q <= 1'b0;
      else if (base_tick && (sub_q == SUB_HALF || sub_q == SUB_LAST)) sclk_q <= ~sclk_q;
    end
  end

  // R4: the synchronous clock is idle low outside synchronous mode
  p_sync_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_mode |=> !sync_clk);
endmodule

// File: rtl/brg_rx_vote.sv
module brg_rx_vote #(
  parameter int SUB_W = 2,
  parameter int OS_W  = 4,
  localparam int LIM_W = OS_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_tick,
  input  logic             os_tick,
  input  logic             bit_strobe,
  input  logic             sync_mode,
  input  logic [SUB_W-1:0] sub_idx,
  input  logic [OS_W-1:0]  os_idx,
  input  logic [LIM_W-1:0] os_limit,
  input  logic             rx_raw,
  output logic             rx_level
);
  logic [2:0]       samp_q;
  logic [2:0]       samp_next;
  logic             samp_en;
  logic [LIM_W-1:0] centre;
  logic [LIM_W-1:0] os_ext;
  logic             level_q;

  assign centre = os_limit >> 1;
  assign os_ext = {1'b0, os_idx};

  always_comb begin
    if (sync_mode)
      samp_en = base_tick && (sub_idx != '0);
    else
      samp_en = os_tick && ((os_ext + 1'b1) >= centre) && (os_ext <= (centre + 1'b1));
  end

  assign samp_next = samp_en ? {samp_q[1:0], rx_raw} : samp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      samp_q  <= '0;
      level_q <= 1'b1;
    end else begin
      samp_q <= samp_next;
      if (bit_strobe)
        level_q <= (samp_next[0] & samp_next[1]) | (samp_next[0] & samp_next[2]) |
                   (samp_next[1] & samp_next[2]);
    end
  end

  assign rx_level = level_q;

  // R7: the voted level moves only after a bit strobe
  p_level_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_strobe |=> $stable(rx_level));
endmodule

// File: rtl/brg_bitrate_gen.sv
module brg_bitrate_gen
  import brg_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             sync_mode,
  input  logic             high_speed,
  input  logic [DIV_W-1:0] div_value,
  input  logic             div_write,
  input  logic             rx_raw,
  output logic             bit_strobe,
  output logic             os_tick,
  output logic             sync_clk,
  output logic             rx_level
);
  localparam int SUB_W = $clog2(SUB_PER_OS);
  localparam int OS_W  = $clog2(OS_PER_BIT_LO);

  logic             base_tick;
  logic             restart;
  logic [SUB_W-1:0] sub_idx;
  logic [OS_W-1:0]  os_idx;
  logic [OS_W:0]    os_limit;

  brg_divider #(.DIV_W(DIV_W)) i_div (
    .clk(clk), .rst_n(rst_n), .enable(enable), .div_write(div_write),
    .div_value(div_value), .base_tick(base_tick), .restart(restart)
  );

  brg_prescaler i_pre (
    .clk(clk), .rst_n(rst_n), .restart(restart), .base_tick(base_tick),
    .sync_mode(sync_mode), .high_speed(high_speed), .os_tick(os_tick),
    .bit_strobe(bit_strobe), .sync_clk(sync_clk), .sub_idx(sub_idx),
    .os_idx(os_idx), .os_limit(os_limit)
  );

  brg_rx_vote #(.SUB_W(SUB_W), .OS_W(OS_W)) i_vote (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .os_tick(os_tick),
    .bit_strobe(bit_strobe), .sync_mode(sync_mode), .sub_idx(sub_idx),
    .os_idx(os_idx), .os_limit(os_limit), .rx_raw(rx_raw), .rx_level(rx_level)
  );

  // R8: no pulses while disabled
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (!bit_strobe && !os_tick));

  // R8: the synchronous clock is parked low one cycle after disable
  p_hold_clk_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !sync_clk);
endmodule

// File: tb/test_brg_bitrate_gen.sv
module test_brg_bitrate_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic sync_mode = 1'b0;
  logic high_speed = 1'b0;
  logic [7:0] div_value = 8'd0;
  logic div_write = 1'b0;
  logic rx_raw = 1'b1;
  logic bit_strobe, os_tick, sync_clk, rx_level;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int exp_level = 1;
  bit done = 1'b0;

  always #2 clk = ~clk;

  brg_bitrate_gen i_brg_bitrate_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sync_mode(sync_mode),
    .high_speed(high_speed), .div_value(div_value), .div_write(div_write),
    .rx_raw(rx_raw), .bit_strobe(bit_strobe), .os_tick(os_tick),
    .sync_clk(sync_clk), .rx_level(rx_level)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s cycle %0d got %0d expected %0d", req, cycles, got, exp);
    end
  endtask

  function automatic int maj3(input int p);
    return ((p & 1) + ((p >> 1) & 1) + ((p >> 2) & 1)) >= 2 ? 1 : 0;
  endfunction

  function automatic int pat_of(input int b, input int n, input int sy, input int hs);
    return (b * 5 + n + 3 * sy + hs) & 7;
  endfunction

  // Starts at a falling edge that lies in cycle 0; checks ncyc cycles.
  task automatic run(input int n, input int sy, input int hs, input int ncyc);
    int per_bit;
    int lsel;
    string breq;
    lsel    = sy ? 1 : (hs ? 4 : 16);
    per_bit = 4 * lsel * (n + 1);
    breq    = sy ? "R4" : (hs ? "R3" : "R2");
    for (int k = 0; k < ncyc; k++) begin
      int m, q, idx, b, pat, tick, exp_os, exp_bit, exp_clk;
      tick = ((k + 1) % (n + 1)) == 0;
      m = (k + 1) / (n + 1);
      q = (m - 1) % 4;
      exp_os  = tick && (m % 4 == 0);
      exp_bit = tick && (m % (4 * lsel) == 0);
      exp_clk = sy ? ((k / (n + 1)) >> 1) & 1 : 0;
      check("R1", os_tick, exp_os);
      check(breq, bit_strobe, exp_bit);
      check("R4", sync_clk, exp_clk);
      check("R7", rx_level, exp_level);
      b = k / per_bit;
      pat = pat_of(b, n, sy, hs);
      idx = -1;
      if (tick) begin
        if (sy) begin
          if (q >= 1) idx = q - 1;
        end else if (q == 3) begin
          int o, p, c;
          o = (m - 1) / 4;
          p = o % lsel;
          c = lsel / 2;
          if (p >= c - 1 && p <= c + 1) idx = p - (c - 1);
        end
      end
      rx_raw = (idx >= 0) ? ((pat >> idx) & 1) : !maj3(pat);
      if (exp_bit) exp_level = maj3(pat);   // R6: vote of the bit just ended
      @(negedge clk);
    end
  endtask

  task automatic write_div(input int n, input int sy, input int hs);
    div_value  = 8'(n);
    sync_mode  = sy[0];
    high_speed = hs[0];
    div_write  = 1'b1;
    @(negedge clk);
    check("R5", bit_strobe | os_tick, 0);
    div_write = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", bit_strobe, 0);
    check("R9", os_tick, 0);
    check("R9", sync_clk, 0);
    check("R9", rx_level, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", rx_level, 1);
    enable = 1'b1;
    // Sweep divisors and modes; each write lands mid-period (R5).
    for (int n = 0; n < 8; n++) begin
      write_div(n, 0, 0); run(n, 0, 0, 8 * 64 * (n + 1));
      write_div(n, 0, 1); run(n, 0, 1, 8 * 16 * (n + 1));
      write_div(n, 1, 0); run(n, 1, 0, 8 * 4 * (n + 1));
      write_div(n, 1, 1); run(n, 1, 1, 8 * 4 * (n + 1));
    end
    // R2: n=25 gives a 1664-clock bit
    write_div(25, 0, 0); run(25, 0, 0, 2 * 1664);
    // R5: write in mid-bit and mid-period, then a different divisor
    write_div(9, 0, 1); run(9, 0, 1, 77);
    write_div(3, 0, 1); run(3, 0, 1, 4 * 16 * 4);
    // R8: disable holds everything
    enable = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      check("R8", bit_strobe, 0);
      check("R8", os_tick, 0);
      check("R8", sync_clk, 0);
      check("R8", rx_level, exp_level);
    end
    // R8: re-enable without a write restarts timing with the kept divisor
    enable = 1'b1;
    run(3, 0, 1, 4 * 16 * 4);
    // R8: disable in synchronous mode parks the clock
    write_div(2, 1, 0); run(2, 1, 0, 7);
    enable = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R8", sync_clk, 0);
    enable = 1'b1;
    run(2, 1, 0, 8 * 4 * 3);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule